// File: doc/BRIEF.md
# Loop-Replaying Micro-op Queue

This block sits between the front end and the rename stage of an out-of-order core. It buffers decoded micro-ops that arrive either from the decoders or from the decoded micro-op cache. It hands them to rename in program order whenever rename can take them. While it buffers, it also looks for a loop whose whole body is resident in the queue. The trigger is a taken branch whose target tag matches an older entry that is still held, provided every entry from that target through the branch belongs to the branch's thread.

Once such a loop is locked, the queue stops accepting input. It delivers any entries older than the loop head once, and then replays the body indefinitely by wrapping from the branch back to the head. A thread-mode input selects what happens to the idle front end. In single-thread mode a gate signal tells fetch and decode to power down. In two-thread mode a yield signal offers the front-end slot to the other thread instead. A flush input, for example from a misprediction at loop exit, empties the queue and ends streaming.

The controller has three named states. FILL is normal buffering. CHECK is a one-cycle search after a group that ends in a taken branch. STREAM is loop replay. The transitions are:
- FILL→CHECK when an accepted group's last micro-op is a taken branch.
- CHECK→STREAM when the search finds a qualifying head.
- CHECK→FILL when it does not.
- Any state→FILL on flush, which takes priority over every other transition.

Top module: `loop_stream_queue`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1, `out_vld` is 0, and both `fe_gate` and `fe_yield` are 0.
- R2: With `in_src`=0 (decoder path) at most 6 lanes (lanes 0..5) of a group are written; `in_cnt` values above 6 are clipped and lanes 6 and 7 are never delivered.
- R3: With `in_src`=1 (micro-op cache path) up to 8 lanes are written. Entries leave in arrival order, at most 6 per cycle, on lanes 0 upward (oldest on lane 0), and only in cycles where `rn_ready` is 1.
- R4: The queue holds DEPTH=144 entries. `in_ready` is 1 only in FILL with at least 8 free entries, so it stays high after 136 entries and drops at 144.
- R5: Only the `in_brt` bit of the last accepted lane (lane `in_cnt`-1 after clipping) is considered; a taken-branch flag on any earlier lane is ignored. In the cycle after a group ending in a taken branch (CHECK), `in_ready` and `out_vld` are 0. The loop locks if a resident entry older than the branch has tag equal to the branch target and all entries from it through the branch carry the branch's thread ID; the youngest such entry becomes the head.
- R6: If the target is not resident, or an entry of another thread lies between target and branch, the block returns to FILL, accepts input again, and delivers every buffered entry exactly once.
- R7: In STREAM no input is accepted. With `rn_ready`=1, 6 entries per cycle are delivered starting at the oldest; after the branch entry delivery wraps to the head entry.
- R8: In STREAM with `two_thread`=0, `fe_gate` is 1 and `fe_yield` is 0.
- R9: In STREAM with `two_thread`=1, `fe_yield` is 1 and `fe_gate` is 0.
- R10: `flush` empties the queue, discards a group offered in the same cycle and cancels streaming. From the next cycle `fe_gate`, `fe_yield` and `out_vld` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_thread | input | 1 | 0: single-thread mode, 1: two-thread mode |
| flush | input | 1 | Redirect: clear queue and cancel streaming |
| in_cnt | input | 4 | Number of valid lanes offered (0..8) |
| in_src | input | 1 | 0: decoder path, 1: micro-op cache path |
| in_pay | input | 8*PAY_W | Lane payloads, lane k at bits k*PAY_W |
| in_tag | input | 8*TAG_W | Lane fetch tags |
| in_tgt | input | 8*TAG_W | Lane branch target tags |
| in_brt | input | 8 | Lane is a taken branch |
| in_tid | input | 8 | Lane thread ID |
| in_ready | output | 1 | Group offered this cycle is accepted |
| rn_ready | input | 1 | Rename accepts micro-ops this cycle |
| out_vld | output | 6 | Valid lanes to rename |
| out_pay | output | 6*PAY_W | Delivered payloads |
| out_tag | output | 6*TAG_W | Delivered tags |
| out_tid | output | 6 | Delivered thread IDs |
| fe_gate | output | 1 | Disable fetch and decode (loop streaming, single thread) |
| fe_yield | output | 1 | Front-end slot free for other thread (loop streaming, two threads) |

## Verification
Two functions can fall in the same cycle. The first pair is flush and enqueue: the bench offers a group while `flush` is high. It then opens rename and judges that nothing from that group is ever delivered. The second pair is flush and active loop replay: the bench raises `flush` while the body is streaming. On the next cycle it expects gate and yield low, no output, and `in_ready` high again.

// File: rtl/lsdq_pkg.sv
package lsdq_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_STREAM = 2'd2
    } lsdq_state_e;

    // Modular wrap for a sum known to be below twice the depth.
    function automatic int wrap_idx(input int v, input int depth);
        return (v >= depth) ? v - depth : v;
    endfunction

endpackage

// File: rtl/lsdq_scan.sv
module lsdq_scan #(
    parameter int DEPTH = 144,
    parameter int TAG_W = 12,
    parameter int PTR_W = 8,
    parameter int CNT_W = 8
) (
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [CNT_W-1:0] count,
    input  logic [TAG_W-1:0] tag_mem [DEPTH],
    input  logic             tid_mem [DEPTH],
    input  logic [TAG_W-1:0] tgt,
    input  logic             tid,
    output logic             hit,
    output logic [PTR_W-1:0] head
);
    import lsdq_pkg::*;

    logic clean;
    int   idx;

    // Walk from the branch (youngest) toward the oldest entry; a foreign
    // thread entry blocks every older candidate.
    always_comb begin
        hit   = 1'b0;
        head  = '0;
        clean = 1'b1;
        idx   = 0;
        for (int a = DEPTH - 1; a >= 0; a--) begin
            if (a < int'(count)) begin
                idx = wrap_idx(int'(rd_ptr) + a, DEPTH);
                if (tid_mem[idx] != tid) begin
                    clean = 1'b0;
                end else if (clean && !hit && (a < int'(count) - 1)
                             && (tag_mem[idx] == tgt)) begin
                    hit  = 1'b1;
                    head = PTR_W'(idx);
                end
            end
        end
    end

endmodule

// File: rtl/lsdq_ctrl.sv
module lsdq_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  grp_br,
    input  logic                  scan_hit,
    input  logic                  two_thread,
    output lsdq_pkg::lsdq_state_e state,
    output logic                  fe_gate,
    output logic                  fe_yield
);
    import lsdq_pkg::*;

    lsdq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL:   nxt = grp_br ? ST_CHECK : ST_FILL;
            ST_CHECK:  nxt = scan_hit ? ST_STREAM : ST_FILL;
            ST_STREAM: nxt = ST_STREAM;
            default:   nxt = ST_FILL;
        endcase
        if (flush) nxt = ST_FILL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nxt;
    end

    always_comb begin
        fe_gate  = 1'b0;
        fe_yield = 1'b0;
        if (state == ST_STREAM) begin
            fe_gate  = !two_thread;
            fe_yield = two_thread;
        end
    end

    // R10: a flush always lands in FILL with the front end released
    p_flush_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ST_FILL && !fe_gate && !fe_yield));

    // R5: streaming is only ever entered from the search cycle
    p_lock_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_STREAM) |-> $past(state) == ST_CHECK);

    // R5: the search lasts exactly one cycle
    p_check_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |=> (state != ST_CHECK));

endmodule

// File: rtl/loop_stream_queue.sv
module loop_stream_queue #(
    parameter int DEPTH     = 144,
    parameter int DEC_LANES = 6,
    parameter int UC_LANES  = 8,
    parameter int OUT_LANES = 6,
    parameter int PAY_W     = 16,
    parameter int TAG_W     = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          two_thread,
    input  logic                          flush,
    input  logic [$clog2(UC_LANES+1)-1:0] in_cnt,
    input  logic                          in_src,
    input  logic [UC_LANES*PAY_W-1:0]     in_pay,
    input  logic [UC_LANES*TAG_W-1:0]     in_tag,
    input  logic [UC_LANES*TAG_W-1:0]     in_tgt,
    input  logic [UC_LANES-1:0]           in_brt,
    input  logic [UC_LANES-1:0]           in_tid,
    output logic                          in_ready,
    input  logic                          rn_ready,
    output logic [OUT_LANES-1:0]          out_vld,
    output logic [OUT_LANES*PAY_W-1:0]    out_pay,
    output logic [OUT_LANES*TAG_W-1:0]    out_tag,
    output logic [OUT_LANES-1:0]          out_tid,
    output logic                          fe_gate,
    output logic                          fe_yield
);
    import lsdq_pkg::*;

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ICNT_W = $clog2(UC_LANES + 1);
    localparam int OCNT_W = $clog2(OUT_LANES + 1);

    logic [PAY_W-1:0] pay_mem [DEPTH];
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic             tid_mem [DEPTH];

    lsdq_state_e       state;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr, str_ptr, head_r, brp_r, chk_pos;
    logic [CNT_W-1:0]  count;
    logic [TAG_W-1:0]  chk_tgt, last_tgt;
    logic              chk_tid, last_tid, last_br;
    logic [ICNT_W-1:0] n_acc;
    logic [OCNT_W-1:0] n_out;
    logic              acc, scan_hit;
    logic [PTR_W-1:0]  scan_head, nxt_str;
    logic [PTR_W-1:0]  lidx [OUT_LANES];

    // Lane clipping by source path
    always_comb begin
        int lim;
        lim   = in_src ? UC_LANES : DEC_LANES;
        n_acc = (int'(in_cnt) > lim) ? ICNT_W'(lim) : in_cnt;
    end

    assign in_ready = (state == ST_FILL) && ((DEPTH - int'(count)) >= UC_LANES);
    assign acc      = in_ready && (n_acc != '0);

    // Only the last accepted lane can close a loop
    always_comb begin
        last_br  = 1'b0;
        last_tgt = '0;
        last_tid = 1'b0;
        for (int k = 0; k < UC_LANES; k++) begin
            if (k == int'(n_acc) - 1) begin
                last_br  = in_brt[k];
                last_tgt = in_tgt[k*TAG_W +: TAG_W];
                last_tid = in_tid[k];
            end
        end
    end

    always_comb begin
        if (state == ST_FILL && rn_ready)
            n_out = (int'(count) > OUT_LANES) ? OCNT_W'(OUT_LANES) : OCNT_W'(count);
        else
            n_out = '0;
    end

    // Output lane indices: linear in FILL, wrapping at the branch in STREAM
    always_comb begin
        logic [PTR_W-1:0] cur;
        cur = str_ptr;
        for (int k = 0; k < OUT_LANES; k++) begin
            if (state == ST_STREAM) begin
                lidx[k] = cur;
                cur = (cur == brp_r) ? head_r
                                     : PTR_W'(wrap_idx(int'(cur) + 1, DEPTH));
            end else begin
                lidx[k] = PTR_W'(wrap_idx(int'(rd_ptr) + k, DEPTH));
            end
        end
        nxt_str = cur;
    end

    always_comb begin
        for (int k = 0; k < OUT_LANES; k++) begin
            out_vld[k]                 = (state == ST_STREAM) ? rn_ready : (k < int'(n_out));
            out_pay[k*PAY_W +: PAY_W]  = pay_mem[lidx[k]];
            out_tag[k*TAG_W +: TAG_W]  = tag_mem[lidx[k]];
            out_tid[k]                 = tid_mem[lidx[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (acc && !flush) begin
            for (int k = 0; k < UC_LANES; k++) begin
                if (k < int'(n_acc)) begin
                    pay_mem[wrap_idx(int'(wr_ptr) + k, DEPTH)] <= in_pay[k*PAY_W +: PAY_W];
                    tag_mem[wrap_idx(int'(wr_ptr) + k, DEPTH)] <= in_tag[k*TAG_W +: TAG_W];
                    tid_mem[wrap_idx(int'(wr_ptr) + k, DEPTH)] <= in_tid[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            str_ptr <= '0;
            head_r  <= '0;
            brp_r   <= '0;
            chk_pos <= '0;
            chk_tgt <= '0;
            chk_tid <= 1'b0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (acc)
                wr_ptr <= PTR_W'(wrap_idx(int'(wr_ptr) + int'(n_acc), DEPTH));
            rd_ptr <= PTR_W'(wrap_idx(int'(rd_ptr) + int'(n_out), DEPTH));
            count  <= count + CNT_W'(acc ? n_acc : '0) - CNT_W'(n_out);
            if (acc && last_br) begin
                chk_tgt <= last_tgt;
                chk_tid <= last_tid;
                chk_pos <= PTR_W'(wrap_idx(int'(wr_ptr) + int'(n_acc) - 1, DEPTH));
            end
            if (state == ST_CHECK && scan_hit) begin
                head_r  <= scan_head;
                brp_r   <= chk_pos;
                str_ptr <= rd_ptr;
            end
            if (state == ST_STREAM && rn_ready)
                str_ptr <= nxt_str;
        end
    end

    lsdq_scan #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_scan (
        .rd_ptr (rd_ptr),
        .count  (count),
        .tag_mem(tag_mem),
        .tid_mem(tid_mem),
        .tgt    (chk_tgt),
        .tid    (chk_tid),
        .hit    (scan_hit),
        .head   (scan_head)
    );

    lsdq_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .grp_br    (acc && last_br),
        .scan_hit  (scan_hit),
        .two_thread(two_thread),
        .state     (state),
        .fe_gate   (fe_gate),
        .fe_yield  (fe_yield)
    );

    // R4: occupancy never exceeds the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7: nothing is written or freed while a loop streams
    p_hold_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !flush) |=> ($stable(wr_ptr) && $stable(count)));

    // R2: a decoder group grows occupancy by at most its lane limit
    p_dec_limit_r2: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (acc && !in_src) |=> (int'(count) <= int'($past(count)) + DEC_LANES));

    // R5: the search cycle neither accepts nor delivers
    p_check_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> (!in_ready && out_vld == '0));

endmodule

// File: tb/test_loop_stream_queue.sv
module test_loop_stream_queue;
    localparam int PAY_W = 16;
    localparam int TAG_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic two_thread = 1'b0;
    logic flush = 1'b0;
    logic [3:0] in_cnt = '0;
    logic in_src = 1'b0;
    logic [8*PAY_W-1:0] in_pay = '0;
    logic [8*TAG_W-1:0] in_tag = '0;
    logic [8*TAG_W-1:0] in_tgt = '0;
    logic [7:0] in_brt = '0;
    logic [7:0] in_tid = '0;
    logic in_ready;
    logic rn_ready = 1'b0;
    logic [5:0] out_vld;
    logic [6*PAY_W-1:0] out_pay;
    logic [6*TAG_W-1:0] out_tag;
    logic [5:0] out_tid;
    logic fe_gate, fe_yield;

    int nchk = 0;
    int nfail = 0;
    int col [512];
    int ncol = 0;

    always #10 clk = ~clk;

    loop_stream_queue i_loop_stream_queue (
        .clk(clk), .rst_n(rst_n), .two_thread(two_thread), .flush(flush),
        .in_cnt(in_cnt), .in_src(in_src), .in_pay(in_pay), .in_tag(in_tag),
        .in_tgt(in_tgt), .in_brt(in_brt), .in_tid(in_tid), .in_ready(in_ready),
        .rn_ready(rn_ready), .out_vld(out_vld), .out_pay(out_pay),
        .out_tag(out_tag), .out_tid(out_tid), .fe_gate(fe_gate), .fe_yield(fe_yield)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 6; k++) begin
                if (out_vld[k]) begin
                    if (ncol < 512) col[ncol] = int'(out_pay[k*PAY_W +: PAY_W]);
                    ncol++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lane(input int k, input int pay, input int tag,
                            input int tgt, input bit brt, input bit tid);
        in_pay[k*PAY_W +: PAY_W] = PAY_W'(pay);
        in_tag[k*TAG_W +: TAG_W] = TAG_W'(tag);
        in_tgt[k*TAG_W +: TAG_W] = TAG_W'(tgt);
        in_brt[k] = brt;
        in_tid[k] = tid;
    endtask

    // Offer a group for one cycle; time is left at posedge + 1
    task automatic send(input int cnt, input bit src);
        in_cnt = 4'(cnt);
        in_src = src;
        @(posedge clk); #1;
        in_cnt = '0;
        in_brt = '0;
        in_tid = '0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        ncol = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_vld == 6'd0, "R1 out_vld", int'(out_vld), 0);
        chk(!fe_gate && !fe_yield, "R1 gate/yield", int'({fe_gate, fe_yield}), 0);
    endtask

    task automatic t_decoder_limit();
        do_flush();
        rn_ready = 1'b1;
        for (int k = 0; k < 8; k++) set_lane(k, 1 + k, 50 + k, 0, 1'b0, 1'b0);
        send(8, 1'b0);
        cycles(3);
        chk(ncol == 6, "R2 decoder lanes delivered", ncol, 6);
        for (int i = 0; i < 6; i++)
            chk(col[i] == 1 + i, "R2 decoder order", col[i], 1 + i);
    endtask

    task automatic t_ucache();
        do_flush();
        rn_ready = 1'b1;
        for (int k = 0; k < 8; k++) set_lane(k, 21 + k, 60 + k, 0, 1'b0, 1'b0);
        send(8, 1'b1);
        chk(out_vld == 6'h3F, "R3 first beat six lanes", int'(out_vld), 63);
        cycles(1);
        chk(out_vld == 6'h03, "R3 second beat two lanes", int'(out_vld), 3);
        cycles(2);
        chk(ncol == 8, "R3 total delivered", ncol, 8);
        for (int i = 0; i < 8; i++)
            chk(col[i] == 21 + i, "R3 order", col[i], 21 + i);
        rn_ready = 1'b0;
        for (int k = 0; k < 8; k++) set_lane(k, 90 + k, 70 + k, 0, 1'b0, 1'b0);
        send(8, 1'b1);
        cycles(2);
        chk(ncol == 8, "R3 held while rename stalls", ncol, 8);
    endtask

    task automatic t_full();
        do_flush();
        rn_ready = 1'b0;
        for (int g = 0; g < 17; g++) begin
            for (int k = 0; k < 8; k++) set_lane(k, g, 300 + k, 0, 1'b0, 1'b0);
            send(8, 1'b1);
        end
        chk(in_ready == 1'b1, "R4 ready at 136", int'(in_ready), 1);
        for (int k = 0; k < 8; k++) set_lane(k, 0, 300 + k, 0, 1'b0, 1'b0);
        send(8, 1'b1);
        chk(in_ready == 1'b0, "R4 not ready at 144", int'(in_ready), 0);
    endtask

    // Builds: pays 10..16, tags 100..106, branch at 106 targeting 101
    task automatic build_loop();
        do_flush();
        rn_ready = 1'b0;
        for (int k = 0; k < 4; k++) set_lane(k, 10 + k, 100 + k, 0, 1'b0, 1'b0);
        send(4, 1'b1);
        for (int k = 0; k < 3; k++) set_lane(k, 14 + k, 104 + k, 101, k == 2, 1'b0);
        send(3, 1'b1);
        chk(in_ready == 1'b0 && out_vld == 6'd0, "R5 search bubble",
            int'({in_ready, out_vld}), 0);
        cycles(1);
    endtask

    task automatic t_stream_single();
        two_thread = 1'b0;
        build_loop();
        chk(fe_gate == 1'b1, "R8 gate high", int'(fe_gate), 1);
        chk(fe_yield == 1'b0, "R8 yield low", int'(fe_yield), 0);
        chk(in_ready == 1'b0, "R7 no input while streaming", int'(in_ready), 0);
        for (int k = 0; k < 2; k++) set_lane(k, 77, 77, 0, 1'b0, 1'b0);
        in_cnt = 4'd2;
        ncol = 0;
        rn_ready = 1'b1;
        cycles(4);
        in_cnt = '0;
        rn_ready = 1'b0;
        chk(ncol == 24, "R7 six per cycle", ncol, 24);
        for (int i = 0; i < 24; i++) begin
            int e;
            e = (i < 7) ? 10 + i : 11 + ((i - 7) % 6);
            chk(col[i] == e, "R7 replay sequence", col[i], e);
        end
    endtask

    task automatic t_flush_stream();
        rn_ready = 1'b1;
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        chk(!fe_gate && !fe_yield, "R10 gate released", int'({fe_gate, fe_yield}), 0);
        chk(out_vld == 6'd0, "R10 queue empty", int'(out_vld), 0);
        chk(in_ready == 1'b1, "R10 input resumes", int'(in_ready), 1);
        rn_ready = 1'b0;
    endtask

    task automatic t_stream_two();
        two_thread = 1'b1;
        build_loop();
        chk(fe_yield == 1'b1, "R9 yield high", int'(fe_yield), 1);
        chk(fe_gate == 1'b0, "R9 gate low", int'(fe_gate), 0);
        do_flush();
        two_thread = 1'b0;
    endtask

    task automatic t_flush_enqueue();
        do_flush();
        rn_ready = 1'b0;
        for (int k = 0; k < 2; k++) set_lane(k, 40 + k, 400 + k, 0, 1'b0, 1'b0);
        flush = 1'b1;
        send(2, 1'b1);
        flush = 1'b0;
        rn_ready = 1'b1;
        cycles(3);
        chk(ncol == 0, "R10 same-cycle group dropped", ncol, 0);
        rn_ready = 1'b0;
    endtask

    task automatic t_mixed_tid();
        do_flush();
        rn_ready = 1'b0;
        for (int k = 0; k < 4; k++) set_lane(k, 50 + k, 200 + k, 0, 1'b0, k == 2);
        send(4, 1'b1);
        set_lane(0, 54, 204, 201, 1'b1, 1'b0);
        send(1, 1'b1);
        cycles(1);
        chk(!fe_gate && in_ready, "R6 foreign thread blocks lock",
            int'({fe_gate, in_ready}), 1);
        rn_ready = 1'b1;
        cycles(3);
        chk(ncol == 5, "R6 drained once", ncol, 5);
        chk(col[4] == 54, "R6 last entry", col[4], 54);
        rn_ready = 1'b0;
    endtask

    task automatic t_not_resident();
        do_flush();
        for (int k = 0; k < 3; k++) set_lane(k, 60 + k, 210 + k, 999, k == 2, 1'b0);
        send(3, 1'b1);
        cycles(1);
        chk(!fe_gate && in_ready, "R6 absent target no lock",
            int'({fe_gate, in_ready}), 1);
    endtask

    task automatic t_early_branch();
        do_flush();
        for (int k = 0; k < 3; k++) set_lane(k, 70 + k, 220 + k, 220, k == 1, 1'b0);
        send(3, 1'b1);
        chk(in_ready == 1'b1, "R5 non-last branch ignored", int'(in_ready), 1);
        cycles(1);
        chk(!fe_gate, "R5 no lock from early lane", int'(fe_gate), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_decoder_limit();
        t_ucache();
        t_full();
        t_stream_single();
        t_flush_stream();
        t_stream_two();
        t_flush_enqueue();
        t_mixed_tid();
        t_not_resident();
        t_early_branch();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule